// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter Slice

This block is a narrow binary up-counter meant to be tiled. Every slice runs on one shared clock, and every control acts at the rising edge. A slice can zero its count, take a parallel value, or step by one. It raises a carry flag at its top count so that the next slice up knows when to step. Chaining that flag into the next slice's carry-side enable gives counters of any width with no ripple between clock domains.

Two enables share the job of gating the count. The hold enable only pauses counting. The carry-side enable also qualifies the carry flag, so a stalled lower slice never lets an upper slice advance.

Because clear and load act at the clock edge, a decoded count fed back into clear or load gives a modulus of one more than the decoded value. Feeding back a load can also make a counter cycle over an arbitrary window.

Top module: `ctr_slice`

## Requirements
- R1: When `clr_n` is low at a rising edge, `q` is 0 after that edge. `q` does not change before the edge.
- R2: When `clr_n` is high and `ld_n` is low at a rising edge, `q` takes the value of `ld_val` at that edge, whatever the enables are.
- R3: When `clr_n`, `ld_n`, `en_p` and `en_t` are all high at a rising edge, `q` increases by one at that edge.
- R4: When `clr_n` and `ld_n` are high and either `en_p` or `en_t` is low, `q` holds its value across the edge.
- R5: Stepping from the all-ones count (15) gives 0.
- R6: `rco` is high exactly when `q` is all ones (15) and `en_t` is high, with no clock delay. `en_p` has no effect on `rco`.
- R7: Clear takes priority over load, and load takes priority over counting.
- R8: Two slices share a clock, with the low slice's `en_t` tied high, the high slice's `en_t` driven by the low slice's `rco`, and `en_p` driven to both. Together they count 0 to 255 and wrap. Counting pauses while `en_p` is low.
- R9: Feeding "q equals K" (inverted) into `clr_n` gives a cycle of K+1 states. With K = 8 the cycle is 0..8.
- R10: Feeding "q equals N2" (inverted) into `ld_n` with `ld_val` = N1 cycles from N1 to N2. With N1 = 3 and N2 = 11 the cycle is 3..11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared rising-edge clock |
| clr_n | input | 1 | Synchronous zeroing, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel take, active low |
| ld_val | input | W (4) | Value taken on a load |
| en_p | input | 1 | Hold enable; gates counting only |
| en_t | input | 1 | Carry-side enable; gates counting and `rco` |
| q | output | W (4) | Current count, bit 0 least significant |
| rco | output | 1 | Carry flag: all ones and `en_t` high |

## Verification
The clocked assertions assume the count has been defined by at least one clear before they are armed. They also assume every control is at a known level at each rising edge. The bench therefore starts every instance with a clear or a forced load, and it changes stimulus only on falling edges. Feedback-built instances keep their decoded controls settled long before each rising edge. The bench sweeps every start count against every combination of the four control inputs and samples `rco` before the edge. Chained and feedback-built arrangements are run through whole cycles.

// File: rtl/ctr_slice_pkg.sv
// Package: shared operation type for the counter slice.
// Assumes: consumers import it before declaring ports that use op_e.
package ctr_slice_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_TAKE  = 2'd2,
        OP_ZERO  = 2'd3
    } op_e;
endpackage

// File: rtl/ctr_slice_sel.sv
// Module: ctr_slice_sel - resolves the four control inputs into one operation.
// Assumes: all controls are sampled by the register at the same rising edge.
module ctr_slice_sel
    import ctr_slice_pkg::*;
(
    input  logic clr_n,
    input  logic ld_n,
    input  logic en_p,
    input  logic en_t,
    output op_e  op
);
    // Purpose: fixed priority zero > take > step > hold.
    always_comb begin
        if (!clr_n)
            op = OP_ZERO;
        else if (!ld_n)
            op = OP_TAKE;
        else if (en_p && en_t)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/ctr_slice_reg.sv
// Module: ctr_slice_reg - count register that applies the selected operation.
// Assumes: op is settled before the rising edge; wraps modulo 2**W.
module ctr_slice_reg
    import ctr_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  op_e          op,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] q_next;

    // Purpose: next count value for each operation.
    always_comb begin
        case (op)
            OP_ZERO: q_next = '0;
            OP_TAKE: q_next = ld_val;
            OP_STEP: q_next = q + ONE;
            default: q_next = q;
        endcase
    end

    // Purpose: the count register itself.
    always_ff @(posedge clk) begin
        q <= q_next;
    end

    // R5
    wrap_to_zero_chk: assert property (@(posedge clk)
        (op == OP_STEP) && (q == {W{1'b1}}) |=> (q == '0));
endmodule

// File: rtl/ctr_slice_carry.sv
// Module: ctr_slice_carry - terminal-count detector qualified by en_t.
// Assumes: purely combinational so an upper slice sees it before the edge.
module ctr_slice_carry #(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         en_t,
    output logic         rco
);
    logic [W:0] chain;

    assign chain[0] = en_t;

    // Per-bit AND chain: carry survives only if every bit is one.
    for (genvar i = 0; i < W; i++) begin : g_and
        assign chain[i+1] = chain[i] & q[i];
    end

    assign rco = chain[W];

    // R6
    always_comb begin
        carry_gate_chk: assert (!(rco && !en_t));
    end
endmodule

// File: rtl/ctr_slice.sv
// Module: ctr_slice - cascadable synchronous binary up-counter slice.
// Assumes: one shared clock for all slices; clr_n is the only reset and is
// applied at least once before the count is relied upon.
module ctr_slice
    import ctr_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic [W-1:0] ld_val,
    input  logic         en_p,
    input  logic         en_t,
    output logic [W-1:0] q,
    output logic         rco
);
    localparam logic [W-1:0] ONE = W'(1);

    op_e op;

    ctr_slice_sel u_sel (
        .clr_n (clr_n),
        .ld_n  (ld_n),
        .en_p  (en_p),
        .en_t  (en_t),
        .op    (op)
    );

    ctr_slice_reg #(.W(W)) u_reg (
        .clk    (clk),
        .op     (op),
        .ld_val (ld_val),
        .q      (q)
    );

    ctr_slice_carry #(.W(W)) u_carry (
        .q    (q),
        .en_t (en_t),
        .rco  (rco)
    );

    // Checker arming: set once a clear has defined the count.
    logic armed = 1'b0;

    // Purpose: remember that the count has been cleared at least once.
    always_ff @(posedge clk) begin
        armed <= armed | ~clr_n;
    end

    // R1
    clear_zero_chk: assert property (@(posedge clk)
        !clr_n |=> (q == '0));

    // R2, R7
    load_take_chk: assert property (@(posedge clk) disable iff (!armed)
        clr_n && !ld_n |=> (q == $past(ld_val)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!armed)
        clr_n && ld_n && en_p && en_t |=> (q == $past(q) + ONE));

    // R4
    hold_still_chk: assert property (@(posedge clk) disable iff (!armed)
        clr_n && ld_n && !(en_p && en_t) |=> $stable(q));

    // R6
    carry_full_chk: assert property (@(posedge clk) disable iff (!armed)
        rco |-> (q == {W{1'b1}}));
endmodule

// File: tb/ctr_slice_tb.sv
module ctr_slice_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Single slice under sweep
    logic       clr_n = 1'b1, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
    logic [3:0] ld_val = '0;
    logic [3:0] q;
    logic       rco;

    ctr_slice #(.W(4)) u_dut (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .ld_val(ld_val),
        .en_p(en_p), .en_t(en_t), .q(q), .rco(rco)
    );

    // Two-slice cascade (R8)
    logic       c_clr_n = 1'b1, c_en_p = 1'b0;
    logic [3:0] c_lo_q, c_hi_q;
    logic       c_lo_rco, c_hi_rco;

    ctr_slice #(.W(4)) u_casc_lo (
        .clk(clk), .clr_n(c_clr_n), .ld_n(1'b1), .ld_val(4'd0),
        .en_p(c_en_p), .en_t(1'b1), .q(c_lo_q), .rco(c_lo_rco)
    );
    ctr_slice #(.W(4)) u_casc_hi (
        .clk(clk), .clr_n(c_clr_n), .ld_n(1'b1), .ld_val(4'd0),
        .en_p(c_en_p), .en_t(c_lo_rco), .q(c_hi_q), .rco(c_hi_rco)
    );

    // Modulo-9 by decoded clear (R9)
    logic       m_init_n = 1'b1;
    logic [3:0] m_q;
    logic       m_rco;
    logic       m_clr_n;
    assign m_clr_n = m_init_n & (m_q != 4'd8);

    ctr_slice #(.W(4)) u_mod9 (
        .clk(clk), .clr_n(m_clr_n), .ld_n(1'b1), .ld_val(4'd0),
        .en_p(1'b1), .en_t(1'b1), .q(m_q), .rco(m_rco)
    );

    // Window 3..11 by decoded load (R10)
    logic       w_init_n = 1'b1;
    logic       w_clr_n  = 1'b1;
    logic [3:0] w_q;
    logic       w_rco;
    logic       w_ld_n;
    assign w_ld_n = w_init_n & (w_q != 4'd11);

    ctr_slice #(.W(4)) u_win (
        .clk(clk), .clr_n(w_clr_n), .ld_n(w_ld_n), .ld_val(4'd3),
        .en_p(1'b1), .en_t(1'b1), .q(w_q), .rco(w_rco)
    );

    task automatic check(input bit ok, input string req,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        // Reset state via clear (R1): q must not move before the edge
        clr_n = 1'b0; ld_n = 1'b0; ld_val = 4'd9; en_p = 1'b1; en_t = 1'b1;
        c_clr_n = 1'b0; m_init_n = 1'b0; w_clr_n = 1'b0;
        tick();
        check(q == 4'd0, "R1 clear (priority R7)", q, 0);
        check(c_lo_q == 0 && c_hi_q == 0, "R1 cascade clear", {c_hi_q, c_lo_q}, 0);
        // R1: clear asserted after a load does not act before the edge
        clr_n = 1'b1; ld_n = 1'b0; ld_val = 4'd6; tick();
        clr_n = 1'b0; ld_n = 1'b1; #1;
        check(q == 4'd6, "R1 no early clear", q, 6);
        tick();
        check(q == 4'd0, "R1 clear at edge", q, 0);

        // Exhaustive sweep: every start count x every control combination
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                clr_n = 1'b1; ld_n = 1'b0; ld_val = 4'(s); en_p = 1'b0; en_t = 1'b0;
                tick();
                clr_n = c[3]; ld_n = c[2]; en_p = c[1]; en_t = c[0];
                ld_val = 4'((s * 7 + 3) & 15);
                #1;
                check(rco == ((s == 15) && c[0]), "R6 carry", rco, (s == 15) && c[0]);
                begin
                    int exp;
                    if (!c[3])                 exp = 0;
                    else if (!c[2])            exp = (s * 7 + 3) & 15;
                    else if (c[1] && c[0])     exp = (s + 1) & 15;
                    else                       exp = s;
                    tick();
                    if (!c[3])            check(q == 4'(exp), "R1/R7 clear wins", q, exp);
                    else if (!c[2])       check(q == 4'(exp), "R2/R7 load wins", q, exp);
                    else if (c[1] && c[0]) check(q == 4'(exp), (s == 15) ? "R5 wrap" : "R3 step", q, exp);
                    else                  check(q == 4'(exp), "R4 hold", q, exp);
                end
            end
        end

        // R6: en_p has no effect on carry at full count
        clr_n = 1'b1; ld_n = 1'b0; ld_val = 4'd15; tick();
        ld_n = 1'b1; en_p = 1'b0; en_t = 1'b1; #1;
        check(rco == 1'b1, "R6 en_p ignored by carry", rco, 1);
        en_t = 1'b0; #1;
        check(rco == 1'b0, "R6 en_t removes carry", rco, 0);
        tick();
        check(q == 4'd15, "R4 hold at full count", q, 15);

        // R8: cascade counts 0..255 and wraps, pausing while en_p low
        c_clr_n = 1'b1;
        begin
            int exp8 = 0;
            for (int k = 0; k < 300; k++) begin
                c_en_p = (k % 37) != 5;
                tick();
                if (c_en_p) exp8 = (exp8 + 1) & 255;
                check({c_hi_q, c_lo_q} == 8'(exp8), "R8 cascade", {c_hi_q, c_lo_q}, exp8);
            end
        end

        // R9: modulo-9 cycle
        m_init_n = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            tick();
            check(m_q == 4'(k % 9), "R9 decoded clear", m_q, k % 9);
        end

        // R10: window 3..11 via decoded load (forced load first)
        w_clr_n = 1'b1; w_init_n = 1'b0; tick();
        check(w_q == 4'd3, "R10 initial load", w_q, 3);
        w_init_n = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            tick();
            check(w_q == 4'(3 + (k % 9)), "R10 window", w_q, 3 + (k % 9));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule